// File: doc/BRIEF.md
# Overvoltage Fault Latch and Recovery Controller

This block guards a two-channel output stage against supply overvoltage. A comparator level enters through a synchronizer and a two-cycle qualifier. While the qualified overvoltage is present, both channel enables are forced low so the outputs float. The mask setting has no effect on this shutdown. The fault is latched into two sticky status bits. An active-low interrupt pin reports the fault unless a mask bit suppresses it.

The register side appears only as strobes and levels. A read strobe marks an access to the fault register. A write strobe loads the mask bit. Two one-cycle retry pulses control the left and right channels separately. In host-controlled mode the channels come back only through those retry pulses. In stand-alone mode a timer, whose length is a parameter, re-enables both channels once the timed interval has passed and the supply is back in range.

Top module: `ovp_guard`

## Requirements
- R1: While the qualified overvoltage level is high, `ch_en` is 2'b00 whatever the mask bit holds.
- R2: `ov_in` passes through two synchronizer flops. It must then be seen high on two consecutive samples to count. A one-cycle pulse sets no status and disables no channel. A level held for two cycles is latched.
- R3: On a qualified fault, `dump_sts` and `flag_sts` both become 1.
- R4: `flag_n` is 0 while `dump_sts` is 1 and `mask_q` is 0, and 1 otherwise. A `mask_wr` pulse loads `mask_din` into `mask_q`.
- R5: A `rd_fault` pulse clears both status bits only when the qualified overvoltage is low. In a cycle where a fault is present, the set wins over the read and the bits stay 1.
- R6: Bit 0 of `ch_en` is the left channel and bit 1 is the right channel. A `retry_l` pulse sets only bit 0 and a `retry_r` pulse sets only bit 1. This works in either mode. In host mode (`mode_auto`=0) nothing else re-enables a channel.
- R7: A retry pulse that arrives while the qualified overvoltage is high is ignored, and the channel stays disabled after the fault clears.
- R8: In stand-alone mode (`mode_auto`=1), about RETRY_CYC cycles after the fault is qualified, both channels are re-enabled if the fault has gone. They are not re-enabled earlier. The status bits stay set until they are read.
- R9: If the fault is still present when the stand-alone interval ends, the interval restarts. The channels come back at the end of the first interval that finds the fault gone.
- R10: After reset, both status bits are 0, `flag_n` is 1, `mask_q` is 0 and `ch_en` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ov_in | input | 1 | Asynchronous overvoltage comparator level |
| mode_auto | input | 1 | 1 = stand-alone timed retry, 0 = host-controlled |
| rd_fault | input | 1 | One-cycle pulse marking a read of the fault register |
| mask_wr | input | 1 | One-cycle pulse that loads the mask bit |
| mask_din | input | 1 | Value loaded into the mask bit |
| retry_l | input | 1 | One-cycle retry pulse, left channel |
| retry_r | input | 1 | One-cycle retry pulse, right channel |
| ch_en | output | 2 | Channel enables, bit 0 left, bit 1 right |
| flag_n | output | 1 | Active-low interrupt flag |
| dump_sts | output | 1 | Sticky overvoltage status bit |
| flag_sts | output | 1 | Sticky flag status bit |
| mask_q | output | 1 | Current mask bit |

## Verification
The assertions check several rules on every cycle:
- the forced shutdown during a qualified fault;
- the status set one cycle after a fault, even when a read arrives in the same cycle;
- that a status bit only falls after a read taken outside a fault;
- that every rising channel enable traces back to a retry pulse or a timer expiry;
- the timer counter's range and its restart when it expires with the fault still present.

Only the bench scenarios can show the rest:
- the two-cycle glitch rejection;
- that recovery needs retry pulses in host mode but not in stand-alone mode;
- that a retry during the fault leaves the channel off afterwards;
- the actual length of the stand-alone interval, including a second interval after a restart.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

    localparam int NUM_CH   = 2;
    localparam int CH_LEFT  = 0;
    localparam int CH_RIGHT = 1;

    typedef enum logic {
        MODE_HOST = 1'b0,
        MODE_AUTO = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic dump;
        logic flag;
    } fault_sts_t;

    // Active-low interrupt pin level from latched status and mask
    function automatic logic flag_pin_level(fault_sts_t s, logic mask);
        return !(s.dump && !mask);
    endfunction

    function automatic op_mode_e decode_mode(logic auto_sel);
        return auto_sel ? MODE_AUTO : MODE_HOST;
    endfunction

endpackage

// File: rtl/ovp_sync.sv
module ovp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous sample
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], d};
    end

    // Two consecutive synchronized samples required
    assign q = sh[STAGES] & sh[STAGES-1];

    AST_QUAL_TWO: assert property (@(posedge clk) disable iff (rst)
        $rose(q) |-> $past(sh[STAGES-1]))  // R2
        else $error("qualified level rose without a prior synchronized sample");

endmodule

// File: rtl/ovp_status.sv
module ovp_status
    import ovp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ov_q,
    input  logic       rd_stb,
    input  logic       mask_wr,
    input  logic       mask_din,
    output fault_sts_t sts,
    output logic       mask_q,
    output logic       flag_n
);
    fault_sts_t sts_nx;
    logic       clr_ok;

    assign clr_ok = rd_stb && !ov_q;

    always_comb begin
        sts_nx = sts;
        if (ov_q) begin
            sts_nx.dump = 1'b1;
            sts_nx.flag = 1'b1;
        end else if (clr_ok) begin
            sts_nx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts    <= '0;
            mask_q <= 1'b0;
        end else begin
            sts <= sts_nx;
            if (mask_wr) mask_q <= mask_din;
        end
    end

    assign flag_n = flag_pin_level(sts, mask_q);

    AST_DUMP_SET: assert property (@(posedge clk) disable iff (rst)
        ov_q |=> (sts.dump && sts.flag))  // R3
        else $error("fault did not set status");

    AST_CLEAR_GATED: assert property (@(posedge clk) disable iff (rst)
        $fell(sts.dump) |-> ($past(rd_stb) && !$past(ov_q)))  // R5
        else $error("status cleared without a read outside a fault");

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_q))  // R4
        else $error("mask changed without a write");

endmodule

// File: rtl/ovp_retry_timer.sv
module ovp_retry_timer
    import ovp_pkg::*;
#(
    parameter int RETRY_CYC = 62_500_000
) (
    input  logic     clk,
    input  logic     rst,
    input  op_mode_e mode,
    input  logic     ov_q,
    output logic     fire
);
    localparam int CNT_W = (RETRY_CYC > 1) ? $clog2(RETRY_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RETRY_CYC - 1);

    logic             pend;
    logic [CNT_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || mode != MODE_AUTO) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (!pend) begin
            if (ov_q) begin
                pend <= 1'b1;
                cnt  <= '0;
            end
        end else if (at_end) begin
            cnt <= '0;
            if (!ov_q) pend <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign fire = pend && at_end && !ov_q && (mode == MODE_AUTO);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST)  // R8
        else $error("retry counter out of range");

    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_AUTO && pend && at_end && ov_q) |=> (pend && cnt == '0))  // R9
        else $error("timer did not restart with fault present");

    AST_HOST_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOST) |=> !pend)  // R6
        else $error("timer armed in host mode");

endmodule

// File: rtl/ovp_chan_ctrl.sv
module ovp_chan_ctrl
    import ovp_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ov_q,
    input  logic [CH-1:0] retry,
    input  logic          fire,
    output logic [CH-1:0] ch_en
);
    logic [CH-1:0] en_q;

    for (genvar i = 0; i < CH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)                   en_q[i] <= 1'b0;
            else if (ov_q)             en_q[i] <= 1'b0;
            else if (retry[i] || fire) en_q[i] <= 1'b1;
        end

        assign ch_en[i] = en_q[i] & ~ov_q;

        AST_RETRY_BLOCKED: assert property (@(posedge clk) disable iff (rst)
            ov_q |=> !en_q[i])  // R7
            else $error("channel armed during fault");

        AST_EN_CAUSE: assert property (@(posedge clk) disable iff (rst)
            $rose(en_q[i]) |-> ($past(retry[i]) || $past(fire)))  // R6
            else $error("channel enabled without retry or timer");
    end

endmodule

// File: rtl/ovp_guard.sv
module ovp_guard
    import ovp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RETRY_CYC   = 62_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ov_in,
    input  logic              mode_auto,
    input  logic              rd_fault,
    input  logic              mask_wr,
    input  logic              mask_din,
    input  logic              retry_l,
    input  logic              retry_r,
    output logic [NUM_CH-1:0] ch_en,
    output logic              flag_n,
    output logic              dump_sts,
    output logic              flag_sts,
    output logic              mask_q
);
    logic              ov_q;
    logic              fire;
    logic [NUM_CH-1:0] retry_v;
    fault_sts_t        sts;
    op_mode_e          mode;

    assign mode              = decode_mode(mode_auto);
    assign retry_v[CH_LEFT]  = retry_l;
    assign retry_v[CH_RIGHT] = retry_r;

    ovp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ov_in),
        .q   (ov_q)
    );

    ovp_status u_status (
        .clk      (clk),
        .rst      (rst),
        .ov_q     (ov_q),
        .rd_stb   (rd_fault),
        .mask_wr  (mask_wr),
        .mask_din (mask_din),
        .sts      (sts),
        .mask_q   (mask_q),
        .flag_n   (flag_n)
    );

    ovp_retry_timer #(.RETRY_CYC(RETRY_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .ov_q (ov_q),
        .fire (fire)
    );

    ovp_chan_ctrl #(.CH(NUM_CH)) u_chan (
        .clk   (clk),
        .rst   (rst),
        .ov_q  (ov_q),
        .retry (retry_v),
        .fire  (fire),
        .ch_en (ch_en)
    );

    assign dump_sts = sts.dump;
    assign flag_sts = sts.flag;

    AST_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
        ov_q |-> (ch_en == '0))  // R1
        else $error("channel enabled during fault");

    AST_FLAG_RAISE: assert property (@(posedge clk) disable iff (rst)
        ($rose(dump_sts) && !mask_q) |-> !flag_n)  // R4
        else $error("unmasked fault did not pull flag low");

endmodule

// File: tb/tb_ovp_guard.sv
module tb_ovp_guard;
    localparam int RC = 40;

    logic       clk = 1'b0;
    logic       rst, ov_in, mode_auto, rd_fault, mask_wr, mask_din, retry_l, retry_r;
    logic [1:0] ch_en;
    logic       flag_n, dump_sts, flag_sts, mask_q;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    ovp_guard #(.SYNC_STAGES(2), .RETRY_CYC(RC)) dut (
        .clk(clk), .rst(rst), .ov_in(ov_in), .mode_auto(mode_auto),
        .rd_fault(rd_fault), .mask_wr(mask_wr), .mask_din(mask_din),
        .retry_l(retry_l), .retry_r(retry_r), .ch_en(ch_en),
        .flag_n(flag_n), .dump_sts(dump_sts), .flag_sts(flag_sts), .mask_q(mask_q)
    );

    // Vector fields: ov rd rl rr mw md | exp_en[1:0] exp_flag_n exp_dump
    localparam int NV = 14;
    localparam logic [9:0] VEC [NV] = '{
        10'b001000_01_1_0,  // R6 left retry
        10'b000100_11_1_0,  // R6 right retry
        10'b100000_00_0_1,  // R1 R3 fault
        10'b110000_00_0_1,  // R5 read during fault
        10'b101000_00_0_1,  // R7 retry during fault
        10'b000000_00_0_1,  // R6 no self recovery
        10'b010000_00_1_0,  // R5 read clears
        10'b001000_01_1_0,  // R6 left only
        10'b000011_01_1_0,  // R4 mask on
        10'b100000_00_1_1,  // R1 R4 masked fault
        10'b000000_00_1_1,  // R4 masked
        10'b010000_00_1_0,  // R5 read clears
        10'b000110_10_1_0,  // R4 R6 mask off, right only
        10'b001000_11_1_0   // R6 left
    };

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic pulse_retry_both();
        retry_l = 1'b1; retry_r = 1'b1;
        cyc(1);
        retry_l = 1'b0; retry_r = 1'b0;
        cyc(3);
    endtask

    task automatic read_fault();
        rd_fault = 1'b1;
        cyc(1);
        rd_fault = 1'b0;
        cyc(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; ov_in = 1'b0; mode_auto = 1'b0; rd_fault = 1'b0;
        mask_wr = 1'b0; mask_din = 1'b0; retry_l = 1'b0; retry_r = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R10 reset state
        chk("R10 ch_en", {2'b0, ch_en}, 4'h0);
        chk("R10 flag_n/mask", {2'b0, flag_n, mask_q}, 4'b0010);
        chk("R10 status", {2'b0, dump_sts, flag_sts}, 4'h0);

        // Vector walk, host mode
        for (int v = 0; v < NV; v++) begin
            ov_in    = VEC[v][9];
            rd_fault = VEC[v][8];
            retry_l  = VEC[v][7];
            retry_r  = VEC[v][6];
            mask_wr  = VEC[v][5];
            mask_din = VEC[v][4];
            cyc(1);
            rd_fault = 1'b0; retry_l = 1'b0; retry_r = 1'b0; mask_wr = 1'b0;
            cyc(5);
            chk($sformatf("vec%0d R1/R6 ch_en", v), {2'b0, ch_en}, {2'b0, VEC[v][3:2]});
            chk($sformatf("vec%0d R4 flag_n", v), {3'b0, flag_n}, {3'b0, VEC[v][1]});
            chk($sformatf("vec%0d R3/R5 status", v), {2'b0, dump_sts, flag_sts},
                {2'b0, VEC[v][0], VEC[v][0]});
        end

        // R2 one-cycle glitch ignored
        ov_in = 1'b1; cyc(1); ov_in = 1'b0; cyc(6);
        chk("R2 glitch status", {3'b0, dump_sts}, 4'h0);
        chk("R2 glitch ch_en", {2'b0, ch_en}, 4'h3);

        // R2 two-cycle level latched
        ov_in = 1'b1; cyc(2); ov_in = 1'b0; cyc(6);
        chk("R2 two-cycle status", {3'b0, dump_sts}, 4'h1);
        chk("R2 two-cycle ch_en", {2'b0, ch_en}, 4'h0);
        read_fault();
        pulse_retry_both();

        // R5 read held during fault onset: set wins, clears only after fault ends
        rd_fault = 1'b1; ov_in = 1'b1; cyc(6);
        chk("R5 set beats read", {2'b0, dump_sts, flag_sts}, 4'h3);
        ov_in = 1'b0; cyc(6);
        chk("R5 clear after fault", {2'b0, dump_sts, flag_sts}, 4'h0);
        rd_fault = 1'b0;
        pulse_retry_both();
        chk("R6 both restored", {2'b0, ch_en}, 4'h3);

        // R8 stand-alone timed retry
        mode_auto = 1'b1; cyc(2);
        ov_in = 1'b1; cyc(3); ov_in = 1'b0;
        cyc(RC / 2);
        chk("R8 not early", {2'b0, ch_en}, 4'h0);
        cyc(RC / 2 + 10);
        chk("R8 auto re-enable", {2'b0, ch_en}, 4'h3);
        chk("R8 status kept", {3'b0, dump_sts}, 4'h1);
        read_fault();

        // R9 fault still present at expiry: interval restarts
        ov_in = 1'b1; cyc(RC + 10);
        chk("R9 off at first expiry", {2'b0, ch_en}, 4'h0);
        cyc(RC / 2 - 10);
        ov_in = 1'b0; cyc(10);
        chk("R9 off before second expiry", {2'b0, ch_en}, 4'h0);
        cyc(RC);
        chk("R9 on after second expiry", {2'b0, ch_en}, 4'h3);
        read_fault();

        // R6 host mode: no timed recovery
        mode_auto = 1'b0; cyc(2);
        ov_in = 1'b1; cyc(3); ov_in = 1'b0;
        cyc(2 * RC + 10);
        chk("R6 host stays off", {2'b0, ch_en}, 4'h0);
        chk("R4 flag low unmasked", {3'b0, flag_n}, 4'h0);

        finish_run();
    end

endmodule